// File: doc/BRIEF.md
# Packet Issue Interlock Scoreboard

This block decides, cycle by cycle, whether the multi-slot instruction packet at the issue stage may leave it. Each slot gives a unit class, two source register indices, a destination index, a condition-field code and two flags: non-excepting and wide (register pair). The block keeps a ready countdown for every general register, every condition field and every per-register error-flag bit. It also keeps a busy countdown for the divider of each slot and a pending bit for every register that waits on memory. If any valid slot names something that is not yet ready, the whole packet is held. When the packet issues, the results it produces are entered into the tables with their unit's latency, in the same cycle.

Load results have no fixed latency. A load marks its destination, or both halves of a pair, pending, and the memory side clears each register with a one-cycle data-valid pulse that carries the register index. Countdowns tick once per clock whether or not a packet is waiting, so time spent stalled counts toward readiness.

Top module: `issue_interlock`

## Requirements
- R1: `stall` is high exactly when `packetValid` is high and at least one valid slot has a hazard, which holds back all slots together. `issue` equals `packetValid` and not `stall`. Both are low when `packetValid` is low.
- R2: A divide (unit code 2) that issues makes its destination register and its condition field busy, so a packet that uses either and is presented in the next cycle stalls for exactly 18 cycles.
- R3: A divide also keeps the divider of its own slot busy for 18 cycles. A divide in that slot in the next cycle stalls 18 cycles. A divide in the other slot does not wait on it.
- R4: A multiply (code 1) writes the even/odd pair holding its destination, with the pair base equal to the destination with bit 0 cleared, and it also writes its condition field. All of these are busy for exactly 1 cycle after issue.
- R5: A simple ALU operation (code 0) or a set-high/low operation (code 6) creates no busy entry, so the next packet may use its results at once.
- R6: The condition-field code is 3 bits wide. Codes 0 to 3 name four separate integer fields, held in entries 4 to 7 of an 8-entry condition register. Codes 4 to 7 mean "no field" and never stall. Only ALU, multiply, divide and branch (code 5) slots look at the field.
- R7: A non-excepting load marks the error-flag bit of each register it writes busy for 2 cycles. A non-excepting divide marks that bit busy for 18 cycles. Only non-excepting loads and divides wait on these bits.
- R8: A store (code 4) checks both sources and its data register, which is the destination field, or the pair when wide. A cache invalidate (code 7) checks only its sources. Neither creates a busy entry.
- R9: A load (code 3) marks its destination pending, or both halves of the pair when wide. A register stays busy until a `ldDoneValid` pulse names it, and the pulse clears only that register, at the next clock.
- R10: Register index 0 and the all-ones index never stall and are never marked busy.
- R11: Countdowns decrease once every clock, including cycles with no packet and cycles that stall.
- R12: Unit codes are 0 ALU, 1 multiply, 2 divide, 3 load, 4 store, 5 branch, 6 set-high/low and 7 cache invalidate. Set-high/low uses no sources. Branch and cache invalidate use no destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| packetValid | input | 1 | A packet is presented for issue |
| slotValid | input | SLOTS | Slot holds an operation |
| slotUnit | input | 3*SLOTS | Unit class code per slot |
| slotSrcA | input | GR_W*SLOTS | First source register per slot |
| slotSrcB | input | GR_W*SLOTS | Second source register per slot |
| slotDst | input | GR_W*SLOTS | Destination (store data) register per slot |
| slotCc | input | 3*SLOTS | Condition-field code per slot |
| slotNonExc | input | SLOTS | Operation is non-excepting |
| slotWide | input | SLOTS | Load/store moves a register pair |
| ldDoneValid | input | 1 | Memory data returned for one register |
| ldDoneReg | input | GR_W | Register whose load data returned |
| stall | output | 1 | Packet held this cycle |
| issue | output | 1 | Packet issues this cycle |

## Verification
The assertions check on every cycle that `stall` and `issue` never overlap, that both stay low without a packet, that a slot-0 divide right behind another slot-0 divide is held, that a read of a freshly multiplied pair is held, and that a packet naming only register 0 and no condition field is never held. The exact stall lengths (18 for divide, 1 for multiply, 2 for the error bit), the independence of condition fields and of per-slot dividers, the pending state of loads and its clearing per register, and countdowns running while no packet waits can only be shown by the bench's directed scenarios, which count stalled cycles against values derived from the requirements.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    U_ALU    = 3'd0,
    U_MUL    = 3'd1,
    U_DIV    = 3'd2,
    U_LOAD   = 3'd3,
    U_STORE  = 3'd4,
    U_BRANCH = 3'd5,
    U_SETHL  = 3'd6,
    U_CINV   = 3'd7
  } unit_e;

  // Strobes from control to the state datapath
  typedef struct packed {
    logic issueGo;
    logic retire;
  } ilkStrobe_t;

  localparam int CC_ENTRIES  = 8;
  localparam int INT_CC_BASE = 4;

endpackage

// File: rtl/ilk_state.sv
module ilk_state
  import ilk_pkg::*;
#(
  parameter int SLOTS       = 2,
  parameter int GR_W        = 5,
  parameter int DIV_LAT     = 18,
  parameter int MUL_LAT     = 1,
  parameter int NEXC_LD_LAT = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ilkStrobe_t              strobe,
  input  logic [SLOTS-1:0]        slotValid,
  input  logic [3*SLOTS-1:0]      slotUnit,
  input  logic [GR_W*SLOTS-1:0]   slotDst,
  input  logic [3*SLOTS-1:0]      slotCc,
  input  logic [SLOTS-1:0]        slotNonExc,
  input  logic [SLOTS-1:0]        slotWide,
  input  logic [GR_W-1:0]         ldDoneReg,
  output logic [(1<<GR_W)-1:0]    grBusy,
  output logic [(1<<GR_W)-1:0]    errBusy,
  output logic [CC_ENTRIES-1:0]   ccBusy,
  output logic [SLOTS-1:0]        divBusy
);

  localparam int NUM_GR = 1 << GR_W;
  localparam int CNT_W  = $clog2(DIV_LAT + 1);
  typedef logic [CNT_W-1:0] cnt_t;

  logic [SLOTS-1:0] wGo, wPair, wLoad, wCc, wDiv;
  logic [GR_W-1:0]  wA [SLOTS];
  logic [GR_W-1:0]  wB [SLOTS];
  cnt_t             wLat [SLOTS];
  cnt_t             eLat [SLOTS];
  logic [1:0]       wCcSel [SLOTS];

  // Decode what each issuing slot writes
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin : decSlot
      unit_e          u;
      logic [GR_W-1:0] d;
      u         = unit_e'(slotUnit[s*3 +: 3]);
      d         = slotDst[s*GR_W +: GR_W];
      wGo[s]    = strobe.issueGo & slotValid[s];
      wPair[s]  = (u == U_MUL) | ((u == U_LOAD) & slotWide[s]);
      wA[s]     = wPair[s] ? {d[GR_W-1:1], 1'b0} : d;
      wB[s]     = {d[GR_W-1:1], 1'b1};
      wLoad[s]  = (u == U_LOAD);
      wDiv[s]   = (u == U_DIV);
      case (u)
        U_MUL:   wLat[s] = cnt_t'(MUL_LAT);
        U_DIV:   wLat[s] = cnt_t'(DIV_LAT);
        default: wLat[s] = '0;
      endcase
      if (slotNonExc[s] && u == U_LOAD)     eLat[s] = cnt_t'(NEXC_LD_LAT);
      else if (slotNonExc[s] && u == U_DIV) eLat[s] = cnt_t'(DIV_LAT);
      else                                  eLat[s] = '0;
      wCc[s]    = ((u == U_MUL) | (u == U_DIV)) & ~slotCc[s*3+2] & (wLat[s] != '0);
      wCcSel[s] = slotCc[s*3 +: 2];
    end
  end

  // Per-register ready countdown, load pending bit, error-flag countdown
  for (genvar r = 0; r < NUM_GR; r++) begin : g_gr
    if (r != 0 && r != NUM_GR - 1) begin : g_trk
      logic ld, pSet, eLd, pend;
      cnt_t val, eVal, cnt, eCnt;

      always_comb begin
        ld   = 1'b0;
        val  = '0;
        pSet = 1'b0;
        eLd  = 1'b0;
        eVal = '0;
        for (int s = 0; s < SLOTS; s++) begin
          if (wGo[s] && (wA[s] == GR_W'(r) || (wPair[s] && wB[s] == GR_W'(r)))) begin
            if (wLat[s] != '0) begin
              ld  = 1'b1;
              val = wLat[s];
            end
            if (wLoad[s]) pSet = 1'b1;
            if (eLat[s] != '0) begin
              eLd  = 1'b1;
              eVal = eLat[s];
            end
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cnt  <= '0;
          eCnt <= '0;
          pend <= 1'b0;
        end else begin
          if (ld)              cnt <= val;
          else if (cnt != '0)  cnt <= cnt - 1'b1;
          if (eLd)             eCnt <= eVal;
          else if (eCnt != '0) eCnt <= eCnt - 1'b1;
          if (pSet)            pend <= 1'b1;
          else if (strobe.retire && ldDoneReg == GR_W'(r)) pend <= 1'b0;
        end
      end

      assign grBusy[r]  = (cnt != '0) | pend;
      assign errBusy[r] = (eCnt != '0);
    end else begin : g_fixed
      assign grBusy[r]  = 1'b0;
      assign errBusy[r] = 1'b0;
    end
  end

  // Condition register: integer fields live in the upper half
  for (genvar e = 0; e < CC_ENTRIES; e++) begin : g_cc
    if (e >= INT_CC_BASE) begin : g_int
      logic ld;
      cnt_t val, cnt;

      always_comb begin
        ld  = 1'b0;
        val = '0;
        for (int s = 0; s < SLOTS; s++) begin
          if (wGo[s] && wCc[s] && ({1'b1, wCcSel[s]} == 3'(e))) begin
            ld  = 1'b1;
            val = wLat[s];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN)          cnt <= '0;
        else if (ld)        cnt <= val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
      end

      assign ccBusy[e] = (cnt != '0);
    end else begin : g_flt
      assign ccBusy[e] = 1'b0;
    end
  end

  // Per-slot divider occupancy
  for (genvar s = 0; s < SLOTS; s++) begin : g_div
    cnt_t cnt;
    always_ff @(posedge clk) begin
      if (!rstN)                cnt <= '0;
      else if (wGo[s] && wDiv[s]) cnt <= cnt_t'(DIV_LAT);
      else if (cnt != '0)       cnt <= cnt - 1'b1;
    end
    assign divBusy[s] = (cnt != '0);
  end

endmodule

// File: rtl/ilk_ctrl.sv
module ilk_ctrl
  import ilk_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int GR_W  = 5
) (
  input  logic                  packetValid,
  input  logic [SLOTS-1:0]      slotValid,
  input  logic [3*SLOTS-1:0]    slotUnit,
  input  logic [GR_W*SLOTS-1:0] slotSrcA,
  input  logic [GR_W*SLOTS-1:0] slotSrcB,
  input  logic [GR_W*SLOTS-1:0] slotDst,
  input  logic [3*SLOTS-1:0]    slotCc,
  input  logic [SLOTS-1:0]      slotNonExc,
  input  logic [SLOTS-1:0]      slotWide,
  input  logic                  ldDoneValid,
  input  logic [(1<<GR_W)-1:0]  grBusy,
  input  logic [(1<<GR_W)-1:0]  errBusy,
  input  logic [CC_ENTRIES-1:0] ccBusy,
  input  logic [SLOTS-1:0]      divBusy,
  output ilkStrobe_t            strobe,
  output logic                  stall
);

  localparam int NUM_GR = 1 << GR_W;

  function automatic logic regHit(input logic [NUM_GR-1:0] v, input logic [GR_W-1:0] x);
    return (x != '0) && (x != '1) && v[x];
  endfunction

  logic [SLOTS-1:0] hazard;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin : chkSlot
      unit_e           u;
      logic [GR_W-1:0] a, b, d, d0, d1;
      logic [2:0]      cc;
      logic useSrc, useDst, pair, useCc, useErr;
      u      = unit_e'(slotUnit[s*3 +: 3]);
      a      = slotSrcA[s*GR_W +: GR_W];
      b      = slotSrcB[s*GR_W +: GR_W];
      d      = slotDst[s*GR_W +: GR_W];
      cc     = slotCc[s*3 +: 3];
      useSrc = (u != U_SETHL);
      useDst = (u != U_BRANCH) && (u != U_CINV);
      pair   = (u == U_MUL) | (((u == U_LOAD) | (u == U_STORE)) & slotWide[s]);
      d0     = pair ? {d[GR_W-1:1], 1'b0} : d;
      d1     = {d[GR_W-1:1], 1'b1};
      useCc  = ((u == U_ALU) | (u == U_MUL) | (u == U_DIV) | (u == U_BRANCH)) & ~cc[2];
      useErr = ((u == U_LOAD) | (u == U_DIV)) & slotNonExc[s];
      hazard[s] = slotValid[s] & (
          (useSrc & (regHit(grBusy, a) | regHit(grBusy, b)))
        | (useDst & (regHit(grBusy, d0) | (pair & regHit(grBusy, d1))))
        | (useCc  & ccBusy[{1'b1, cc[1:0]}])
        | (useErr & (regHit(errBusy, d0) | (pair & regHit(errBusy, d1))))
        | ((u == U_DIV) & divBusy[s]));
    end
  end

  assign stall          = packetValid & (|hazard);
  assign strobe.issueGo = packetValid & ~(|hazard);
  assign strobe.retire  = ldDoneValid;

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter int SLOTS       = 2,
  parameter int GR_W        = 5,
  parameter int DIV_LAT     = 18,
  parameter int MUL_LAT     = 1,
  parameter int NEXC_LD_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  packetValid,
  input  logic [SLOTS-1:0]      slotValid,
  input  logic [3*SLOTS-1:0]    slotUnit,
  input  logic [GR_W*SLOTS-1:0] slotSrcA,
  input  logic [GR_W*SLOTS-1:0] slotSrcB,
  input  logic [GR_W*SLOTS-1:0] slotDst,
  input  logic [3*SLOTS-1:0]    slotCc,
  input  logic [SLOTS-1:0]      slotNonExc,
  input  logic [SLOTS-1:0]      slotWide,
  input  logic                  ldDoneValid,
  input  logic [GR_W-1:0]       ldDoneReg,
  output logic                  stall,
  output logic                  issue
);

  localparam int NUM_GR = 1 << GR_W;

  ilkStrobe_t            strobe;
  logic [NUM_GR-1:0]     grBusy, errBusy;
  logic [CC_ENTRIES-1:0] ccBusy;
  logic [SLOTS-1:0]      divBusy;

  ilk_ctrl #(.SLOTS(SLOTS), .GR_W(GR_W)) u_ctrl (
    .packetValid(packetValid), .slotValid(slotValid), .slotUnit(slotUnit),
    .slotSrcA(slotSrcA), .slotSrcB(slotSrcB), .slotDst(slotDst),
    .slotCc(slotCc), .slotNonExc(slotNonExc), .slotWide(slotWide),
    .ldDoneValid(ldDoneValid), .grBusy(grBusy), .errBusy(errBusy),
    .ccBusy(ccBusy), .divBusy(divBusy), .strobe(strobe), .stall(stall)
  );

  ilk_state #(.SLOTS(SLOTS), .GR_W(GR_W), .DIV_LAT(DIV_LAT),
              .MUL_LAT(MUL_LAT), .NEXC_LD_LAT(NEXC_LD_LAT)) u_state (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotValid(slotValid),
    .slotUnit(slotUnit), .slotDst(slotDst), .slotCc(slotCc),
    .slotNonExc(slotNonExc), .slotWide(slotWide), .ldDoneReg(ldDoneReg),
    .grBusy(grBusy), .errBusy(errBusy), .ccBusy(ccBusy), .divBusy(divBusy)
  );

  assign issue = strobe.issueGo;

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int GR_W = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            packetValid,
  input logic            valid0,
  input logic            valid1,
  input logic [2:0]      unit0,
  input logic [GR_W-1:0] srcA0,
  input logic [GR_W-1:0] srcB0,
  input logic [GR_W-1:0] dst0,
  input logic [2:0]      cc0,
  input logic            stall,
  input logic            issue
);

  AST_STALL_ISSUE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(stall && issue)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !packetValid |-> (!stall && !issue)); // R1

  AST_DIV_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (issue && valid0 && unit0 == 3'd2)
      |=> ((packetValid && valid0 && unit0 == 3'd2) -> stall)); // R3

  AST_MUL_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (issue && valid0 && unit0 == 3'd1 && dst0[GR_W-1:1] != '0)
      |=> ((packetValid && valid0 && unit0 == 3'd0 && srcA0 != '1 &&
            srcA0[GR_W-1:1] == $past(dst0[GR_W-1:1])) -> stall)); // R4

  AST_ZERO_REG_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (packetValid && valid0 && !valid1 && unit0 == 3'd0 && srcA0 == '0 &&
     srcB0 == '0 && dst0 == '0 && cc0 == 3'd7) |-> !stall); // R10

endmodule

bind issue_interlock ilk_checker #(.GR_W(GR_W)) u_chk (
  .clk(clk), .rstN(rstN), .packetValid(packetValid),
  .valid0(slotValid[0]), .valid1(slotValid[SLOTS-1]),
  .unit0(slotUnit[2:0]), .srcA0(slotSrcA[GR_W-1:0]), .srcB0(slotSrcB[GR_W-1:0]),
  .dst0(slotDst[GR_W-1:0]), .cc0(slotCc[2:0]), .stall(stall), .issue(issue)
);

// File: tb/sim_issue_interlock.sv
`timescale 1ns/1ps
module sim_issue_interlock;

  localparam int S = 2;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic packetValid = 1'b0;
  logic [S-1:0]   slotValid = '0;
  logic [3*S-1:0] slotUnit = '0;
  logic [W*S-1:0] slotSrcA = '0, slotSrcB = '0, slotDst = '0;
  logic [3*S-1:0] slotCc = '1;
  logic [S-1:0]   slotNonExc = '0, slotWide = '0;
  logic ldDoneValid = 1'b0;
  logic [W-1:0] ldDoneReg = '0;
  logic stall, issue;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  issue_interlock #(.SLOTS(S), .GR_W(W)) u0 (
    .clk(clk), .rstN(rstN), .packetValid(packetValid), .slotValid(slotValid),
    .slotUnit(slotUnit), .slotSrcA(slotSrcA), .slotSrcB(slotSrcB),
    .slotDst(slotDst), .slotCc(slotCc), .slotNonExc(slotNonExc),
    .slotWide(slotWide), .ldDoneValid(ldDoneValid), .ldDoneReg(ldDoneReg),
    .stall(stall), .issue(issue)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clrSlots();
    slotValid = '0; slotUnit = '0; slotSrcA = '0; slotSrcB = '0;
    slotDst = '0; slotCc = '1; slotNonExc = '0; slotWide = '0;
  endtask

  task automatic setSlot(input int s, input logic [2:0] u, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] d,
                         input logic [2:0] cc, input logic ne, input logic wd);
    slotValid[s] = 1'b1;
    slotUnit[s*3 +: 3] = u;
    slotSrcA[s*W +: W] = a;
    slotSrcB[s*W +: W] = b;
    slotDst[s*W +: W]  = d;
    slotCc[s*3 +: 3]   = cc;
    slotNonExc[s] = ne;
    slotWide[s]   = wd;
  endtask

  // Present the slots set at this negedge; count stalled cycles until issue.
  task automatic issueCount(output int n);
    n = 0;
    packetValid = 1'b1;
    #1;
    while (stall && n < 60) begin
      @(negedge clk); #1;
      n++;
    end
    @(negedge clk);
    packetValid = 1'b0;
    clrSlots();
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic ldPulse(input logic [W-1:0] r);
    ldDoneValid = 1'b1; ldDoneReg = r;
    @(negedge clk);
    ldDoneValid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(stall == 1'b0, "R1 reset stall", stall, 0);
    check(issue == 1'b0, "R1 reset issue", issue, 0);
  endtask

  task automatic t_divide();
    int n;
    setSlot(0, 3'd2, 5'd1, 5'd2, 5'd3, 3'd0, 1'b0, 1'b0);
    setSlot(1, 3'd0, 5'd0, 5'd0, 5'd9, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    check(n == 0, "R2 divide issues", n, 0);
    setSlot(0, 3'd0, 5'd3, 5'd0, 5'd5, 3'd7, 1'b0, 1'b0);
    setSlot(1, 3'd0, 5'd1, 5'd0, 5'd6, 3'd7, 1'b0, 1'b0);
    packetValid = 1'b1; #1;
    check(stall == 1'b1 && issue == 1'b0, "R1 whole packet held", issue, 0);
    issueCount(n);
    check(n == 18, "R2 divide dst wait", n, 18);
    idle(20);
  endtask

  task automatic t_divider();
    int n;
    setSlot(0, 3'd2, 5'd0, 5'd0, 5'd4, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    setSlot(0, 3'd2, 5'd0, 5'd0, 5'd6, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    check(n == 18, "R3 same-slot divider", n, 18);
    setSlot(1, 3'd2, 5'd0, 5'd0, 5'd11, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    check(n == 0, "R3 other-slot divider free", n, 0);
    idle(20);
  endtask

  task automatic t_multiply();
    int n;
    setSlot(0, 3'd1, 5'd1, 5'd2, 5'd8, 3'd3, 1'b0, 1'b0);
    issueCount(n);
    setSlot(0, 3'd0, 5'd9, 5'd0, 5'd0, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    check(n == 1, "R4 odd half of pair", n, 1);
    setSlot(0, 3'd1, 5'd1, 5'd2, 5'd9, 3'd3, 1'b0, 1'b0);
    issueCount(n);
    setSlot(1, 3'd5, 5'd0, 5'd0, 5'd0, 3'd3, 1'b0, 1'b0);
    issueCount(n);
    check(n == 1, "R4 multiply cc field", n, 1);
    idle(3);
  endtask

  task automatic t_alu();
    int n;
    setSlot(0, 3'd0, 5'd1, 5'd2, 5'd10, 3'd1, 1'b0, 1'b0);
    setSlot(1, 3'd6, 5'd0, 5'd0, 5'd12, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    setSlot(0, 3'd5, 5'd10, 5'd12, 5'd0, 3'd1, 1'b0, 1'b0);
    issueCount(n);
    check(n == 0, "R5 alu and set-high/low ready", n, 0);
  endtask

  task automatic t_ccfields();
    int n;
    setSlot(0, 3'd2, 5'd0, 5'd0, 5'd13, 3'd2, 1'b0, 1'b0);
    issueCount(n);
    setSlot(0, 3'd5, 5'd0, 5'd0, 5'd0, 3'd1, 1'b0, 1'b0);
    issueCount(n);
    check(n == 0, "R6 other field free", n, 0);
    setSlot(0, 3'd5, 5'd0, 5'd0, 5'd0, 3'd6, 1'b0, 1'b0);
    issueCount(n);
    check(n == 0, "R6 no-field code", n, 0);
    setSlot(0, 3'd5, 5'd0, 5'd0, 5'd0, 3'd2, 1'b0, 1'b0);
    issueCount(n);
    check(n == 16, "R6 same field held", n, 16);
    idle(20);
  endtask

  task automatic t_store();
    int n;
    setSlot(0, 3'd4, 5'd16, 5'd0, 5'd17, 3'd7, 1'b0, 1'b1);
    setSlot(1, 3'd7, 5'd18, 5'd19, 5'd0, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    setSlot(0, 3'd0, 5'd16, 5'd17, 5'd18, 3'd7, 1'b0, 1'b0);
    setSlot(1, 3'd0, 5'd19, 5'd0, 5'd0, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    check(n == 0, "R8 store leaves no busy", n, 0);
    setSlot(0, 3'd3, 5'd0, 5'd0, 5'd18, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    setSlot(0, 3'd4, 5'd0, 5'd0, 5'd19, 3'd7, 1'b0, 1'b1);
    packetValid = 1'b1;
    repeat (3) begin
      #1;
      check(stall == 1'b1, "R8 store data waits on pair", stall, 1);
      @(negedge clk);
    end
    ldPulse(5'd18);
    #1;
    check(issue == 1'b1, "R8 store issues after data", issue, 1);
    @(negedge clk);
    packetValid = 1'b0; clrSlots();
    setSlot(0, 3'd7, 5'd16, 5'd0, 5'd18, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    check(n == 0, "R12 cache invalidate sources", n, 0);
  endtask

  task automatic t_loadpair();
    int n;
    setSlot(0, 3'd3, 5'd0, 5'd0, 5'd21, 3'd7, 1'b0, 1'b1);
    issueCount(n);
    setSlot(0, 3'd0, 5'd21, 5'd0, 5'd0, 3'd7, 1'b0, 1'b0);
    packetValid = 1'b1;
    #1; check(stall == 1'b1, "R9 odd half pending", stall, 1);
    @(negedge clk); #1;
    check(stall == 1'b1, "R9 pending holds", stall, 1);
    ldDoneValid = 1'b1; ldDoneReg = 5'd21;
    @(negedge clk);
    ldDoneValid = 1'b0; #1;
    check(issue == 1'b1, "R9 cleared by data-valid", issue, 1);
    @(negedge clk);
    packetValid = 1'b0; clrSlots();
    setSlot(0, 3'd0, 5'd20, 5'd0, 5'd0, 3'd7, 1'b0, 1'b0);
    packetValid = 1'b1; #1;
    check(stall == 1'b1, "R9 even half still pending", stall, 1);
    ldDoneValid = 1'b1; ldDoneReg = 5'd20;
    @(negedge clk);
    ldDoneValid = 1'b0; #1;
    check(issue == 1'b1, "R9 even half cleared", issue, 1);
    @(negedge clk);
    packetValid = 1'b0; clrSlots();
  endtask

  task automatic t_errflag();
    int n;
    setSlot(0, 3'd3, 5'd0, 5'd0, 5'd22, 3'd7, 1'b1, 1'b0);
    setSlot(1, 3'd3, 5'd0, 5'd0, 5'd24, 3'd7, 1'b1, 1'b0);
    issueCount(n);
    ldDoneValid = 1'b1; ldDoneReg = 5'd22;
    @(negedge clk);
    ldDoneReg = 5'd24;
    @(negedge clk);
    ldDoneValid = 1'b0;
    setSlot(0, 3'd0, 5'd0, 5'd0, 5'd24, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    check(n == 0, "R7 plain op ignores error bit", n, 0);
    setSlot(0, 3'd3, 5'd0, 5'd0, 5'd22, 3'd7, 1'b1, 1'b0);
    issueCount(n);
    check(n == 0, "R7 error bit expired after 2", n, 0);
    ldPulse(5'd22);
    setSlot(0, 3'd3, 5'd0, 5'd0, 5'd25, 3'd7, 1'b1, 1'b0);
    issueCount(n);
    ldPulse(5'd25);
    setSlot(0, 3'd3, 5'd0, 5'd0, 5'd25, 3'd7, 1'b1, 1'b0);
    issueCount(n);
    check(n == 1, "R7 non-excepting load waits", n, 1);
    ldPulse(5'd25);
  endtask

  task automatic t_zero();
    int n;
    setSlot(0, 3'd2, 5'd0, 5'd0, 5'd0, 3'd7, 1'b0, 1'b0);
    setSlot(1, 3'd3, 5'd0, 5'd0, 5'd31, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    setSlot(0, 3'd0, 5'd0, 5'd31, 5'd0, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    check(n == 0, "R10 index 0 and all-ones", n, 0);
    idle(20);
  endtask

  task automatic t_tick();
    int n;
    setSlot(0, 3'd2, 5'd0, 5'd0, 5'd28, 3'd7, 1'b0, 1'b0);
    setSlot(1, 3'd2, 5'd0, 5'd0, 5'd29, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    idle(17);
    setSlot(0, 3'd0, 5'd29, 5'd0, 5'd0, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    check(n == 1, "R11 countdown during idle", n, 1);
    setSlot(0, 3'd0, 5'd28, 5'd0, 5'd0, 3'd7, 1'b0, 1'b0);
    issueCount(n);
    check(n == 0, "R11 countdown expired", n, 0);
  endtask

  initial begin
    clrSlots();
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_divide();
    t_divider();
    t_multiply();
    t_alu();
    t_ccfields();
    t_store();
    t_loadpair();
    t_errflag();
    t_zero();
    t_tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule